// File: doc/BRIEF.md
# SIMD Per-Lane Blend Unit

This unit assembles a 128-bit result one lane at a time. Each lane is copied from one of two candidate vectors. The lane width is 16, 32 or 64 bits. Two ways of choosing are supported:

- **Mask mode.** A bit of an 8-bit immediate steers each lane between operand A and operand B.
- **Sign mode.** The most significant bit of each lane of operand A acts as a per-lane selector. It chooses between operand B and operand C.

A request carries the mode, an element-size code, the three operands and the immediate. The request is taken when `in_valid` and `in_ready` are both high. The result appears in an output register one cycle later and is held there until the consumer takes it. Sign mode has no 16-bit form. Asking for it raises an error flag on the result, and operand B is then passed through unchanged.

Top module: `simd_blend_unit`

## Requirements
- R1: In mask mode (`mode`=0) with `esize`=0 (16-bit lanes, eight lanes), result lane i takes lane i of `src_a` when `imm[i]` is 0 and lane i of `src_b` when `imm[i]` is 1. Lane i occupies bits [16i+15:16i].
- R2: In mask mode with `esize`=1 (32-bit lanes, four lanes), `imm[3:0]` steer lanes 3..0 with the same polarity as R1. `imm[7:4]` have no effect on the result.
- R3: In mask mode with `esize`=2 (64-bit lanes, two lanes), `imm[1:0]` steer lanes 1..0 with the same polarity as R1. `imm[7:2]` have no effect on the result.
- R4: In sign mode (`mode`=1) with `esize`=1, a 32-bit lane whose `src_a` bit 31 is set takes `src_c`, and otherwise takes `src_b`. The remaining `src_a` bits of the lane do not affect the result.
- R5: In sign mode with `esize`=2, a 64-bit lane whose `src_a` bit 63 is set takes `src_c`, and otherwise takes `src_b`. The remaining `src_a` bits do not affect the result.
- R6: Sign mode with `esize`=0 produces `out_err`=1 and `out_data`=`src_b`. Every other request produces `out_err`=0.
- R7: A request accepted on a rising edge (`in_valid` and `in_ready` both high) is presented on `out_data`/`out_err` with `out_valid` high after exactly that edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`, `out_err` and `out_valid` hold their values.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_data` and `out_err` to zero on the next edge.
- R10: `esize`=3 behaves exactly like `esize`=2 (64-bit lanes) in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| mode | input | 1 | 0 = mask mode, 1 = sign mode |
| esize | input | 2 | Lane width code: 0 = 16, 1 = 32, 2 or 3 = 64 bits |
| src_a | input | 128 | First data operand (mask mode) or selector vector (sign mode) |
| src_b | input | 128 | Second data operand |
| src_c | input | 128 | Third data operand (used in sign mode only) |
| imm | input | 8 | Lane mask (mask mode only) |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Blended result |
| out_err | output | 1 | Sign mode was requested at 16-bit lane width |

## Verification
Mask mode is tried with these immediates:
- All-zero and all-one immediates, which show whether the whole vector comes from one source.
- An alternating immediate, which catches a lane-order or polarity swap.
- Immediates whose high bits contradict the low bits at 32-bit and 64-bit widths, which separate the lanes that are really steered from bits that must be ignored.

Sign mode is tried with these selectors:
- Values such as 0x80000000 against 0x7FFFFFFF and all-ones against 0x00000001, so that only the top bit of each lane, not the magnitude or the low bits, can explain the outcome.

The remaining tests cover the following:
- The 16-bit sign-mode error pass-through.
- The reserved size code.
- A stalled consumer with a competing request waiting.
- A reset issued while a result is held.

// File: rtl/blend_pkg.sv
package blend_pkg;

  typedef enum logic {
    BLEND_MASK = 1'b0,
    BLEND_SIGN = 1'b1
  } blend_mode_e;

  typedef enum logic [1:0] {
    ESZ_16  = 2'd0,
    ESZ_32  = 2'd1,
    ESZ_64  = 2'd2,
    ESZ_64R = 2'd3
  } esize_e;

endpackage

// File: rtl/blend_mask_gen.sv
module blend_mask_gen
  import blend_pkg::*;
#(
  parameter int NCHUNK = 8,
  parameter int C32    = 2,
  parameter int C64    = 4,
  localparam int N32   = NCHUNK / C32,
  localparam int N64   = NCHUNK / C64
) (
  input  logic              mode,
  input  logic [1:0]        esize,
  input  logic [NCHUNK-1:0] imm,
  input  logic [N32-1:0]    sign32,
  input  logic [N64-1:0]    sign64,
  output logic [NCHUNK-1:0] pick_alt,
  output logic              err
);

  blend_mode_e md;
  esize_e      es;

  assign md  = blend_mode_e'(mode);
  assign es  = esize_e'(esize);
  assign err = (md == BLEND_SIGN) && (es == ESZ_16);

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    always_comb begin
      pick_alt[k] = 1'b0;
      if (md == BLEND_MASK) begin
        unique case (es)
          ESZ_16:  pick_alt[k] = imm[k];
          ESZ_32:  pick_alt[k] = imm[k / C32];
          default: pick_alt[k] = imm[k / C64];
        endcase
      end else begin
        unique case (es)
          ESZ_16:  pick_alt[k] = 1'b0;
          ESZ_32:  pick_alt[k] = sign32[k / C32];
          default: pick_alt[k] = sign64[k / C64];
        endcase
      end
    end
  end

endmodule

// File: rtl/blend_datapath.sv
module blend_datapath #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16,
  localparam int NCHUNK = DATA_W / CHUNK_W
) (
  input  logic              mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [NCHUNK-1:0] pick_alt,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] base_v;
  logic [DATA_W-1:0] alt_v;

  assign base_v = mode ? src_b : src_a;
  assign alt_v  = mode ? src_c : src_b;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_mux
    assign result[k*CHUNK_W +: CHUNK_W] =
      pick_alt[k] ? alt_v[k*CHUNK_W +: CHUNK_W] : base_v[k*CHUNK_W +: CHUNK_W];
  end

endmodule

// File: rtl/blend_out_reg.sv
module blend_out_reg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_data;
      out_err   <= d_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> !out_valid && (out_data == '0) && !out_err);

endmodule

// File: rtl/simd_blend_unit.sv
module simd_blend_unit #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16,
  localparam int NCHUNK = DATA_W / CHUNK_W,
  localparam int C32    = 32 / CHUNK_W,
  localparam int C64    = 64 / CHUNK_W,
  localparam int N32    = NCHUNK / C32,
  localparam int N64    = NCHUNK / C64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              mode,
  input  logic [1:0]        esize,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [NCHUNK-1:0] imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);

  logic [N32-1:0]    sign32;
  logic [N64-1:0]    sign64;
  logic [NCHUNK-1:0] pick_alt;
  logic              err_c;
  logic [DATA_W-1:0] result_c;

  for (genvar j = 0; j < N32; j++) begin : g_s32
    assign sign32[j] = src_a[j*32 + 31];
  end
  for (genvar j = 0; j < N64; j++) begin : g_s64
    assign sign64[j] = src_a[j*64 + 63];
  end

  blend_mask_gen #(.NCHUNK(NCHUNK), .C32(C32), .C64(C64)) u_mask (
    .mode(mode), .esize(esize), .imm(imm),
    .sign32(sign32), .sign64(sign64),
    .pick_alt(pick_alt), .err(err_c)
  );

  blend_datapath #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_dp (
    .mode(mode), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .pick_alt(pick_alt), .result(result_c)
  );

  blend_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .d_data(result_c), .d_err(err_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err)
  );

  assert_err16_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && mode && (esize == 2'd0)
    |=> out_err && (out_data == $past(src_b)));

  assert_mask64_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !mode && (esize == 2'd2)
    |=> out_data[63:0] == ($past(imm[0]) ? $past(src_b[63:0]) : $past(src_a[63:0])));

  assert_sign32_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && mode && (esize == 2'd1)
    |=> out_data[31:0] == ($past(src_a[31]) ? $past(src_c[31:0]) : $past(src_b[31:0])));

  assert_sign64_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && mode && (esize[1] == 1'b1)
    |=> out_data[127:64] == ($past(src_a[127]) ? $past(src_c[127:64]) : $past(src_b[127:64])));

  assert_noerr_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !(mode && (esize == 2'd0)) |=> !out_err);

endmodule

// File: tb/simd_blend_unit_bench.sv
module simd_blend_unit_bench;

  localparam int W = 128;
  localparam logic [W-1:0] VB = 128'hB0B1B2B3_B4B5B6B7_B8B9BABB_BCBDBEBF;
  localparam logic [W-1:0] VC = 128'hC0C1C2C3_C4C5C6C7_C8C9CACB_CCCDCECF;
  localparam int NV = 14;
  // {mode, esize, imm, src_a}
  localparam logic [138:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'hA5, 128'h01234567_89ABCDEF_FEDCBA98_76543210},
    {1'b0, 2'd0, 8'h00, 128'h11112222_33334444_55556666_77778888},
    {1'b0, 2'd0, 8'hFF, 128'h11112222_33334444_55556666_77778888},
    {1'b0, 2'd1, 8'hF6, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF},
    {1'b0, 2'd1, 8'h09, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF},
    {1'b0, 2'd2, 8'hFD, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF},
    {1'b0, 2'd2, 8'h02, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF},
    {1'b0, 2'd3, 8'hFE, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF},
    {1'b1, 2'd1, 8'h00, 128'h80000000_7FFFFFFF_FFFFFFFF_00000001},
    {1'b1, 2'd1, 8'hFF, 128'h7FFFFFFF_80000000_00000000_FFFFFFFF},
    {1'b1, 2'd2, 8'h00, 128'h80000000_00000000_7FFFFFFF_FFFFFFFF},
    {1'b1, 2'd2, 8'hFF, 128'h0FFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
    {1'b1, 2'd0, 8'hFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
    {1'b1, 2'd3, 8'h00, 128'h7FFFFFFF_FFFFFFFF_80000000_00000000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic mode = 1'b0;
  logic [1:0] esize = 2'd0;
  logic [W-1:0] src_a = '0, src_b = '0, src_c = '0;
  logic [7:0] imm = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  simd_blend_unit u_simd_blend_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .esize(esize), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .imm(imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err)
  );

  function automatic logic [W:0] model(logic md, logic [1:0] es, logic [7:0] im,
                                       logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    int lw, n;
    logic s;
    lw = (es == 2'd0) ? 16 : (es == 2'd1) ? 32 : 64;
    n  = W / lw;
    if (md && lw == 16) return {1'b1, b};
    r = '0;
    for (int i = 0; i < n; i++) begin
      s = md ? a[i*lw + lw - 1] : im[i];
      for (int j = 0; j < lw; j++)
        r[i*lw + j] = s ? (md ? c[i*lw + j] : b[i*lw + j]) : (md ? b[i*lw + j] : a[i*lw + j]);
    end
    return {1'b0, r};
  endfunction

  task automatic chk(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic md, logic [1:0] es);
    if (!md) return (es == 2'd0) ? "R1" : (es == 2'd1) ? "R2" : (es == 2'd2) ? "R3" : "R10";
    return (es == 2'd0) ? "R6" : (es == 2'd1) ? "R4" : (es == 2'd2) ? "R5" : "R10";
  endfunction

  task automatic drive(logic [138:0] v);
    {mode, esize, imm, src_a} = v;
    src_b = VB;
    src_c = VC;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W:0] e;
    logic [W:0] e2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 reset state", {out_valid, out_err, out_data}, '0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v]);
      in_valid = 1'b1;
      e = model(mode, esize, imm, src_a, src_b, src_c);
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag_of(VEC[v][138], VEC[v][137:136]), " R7 result"}, {out_err, out_data}, e);
      chk("R7 valid after one edge", {128'd0, out_valid}, {128'd0, 1'b1});
    end

    // R10: size code 3 matches size code 2 in mask mode
    @(negedge clk);
    drive({1'b0, 2'd3, 8'h01, 128'h55555555_55555555_AAAAAAAA_AAAAAAAA});
    e = model(1'b0, 2'd2, 8'h01, src_a, VB, VC);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 size code 3 as 64", {out_err, out_data}, e);

    // R8 backpressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[0]);
    e = model(mode, esize, imm, src_a, src_b, src_c);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VEC[5]);
    e2 = model(mode, esize, imm, src_a, src_b, src_c);
    chk("R8 in_ready low while stalled", {128'd0, in_ready}, '0);
    @(negedge clk);
    @(negedge clk);
    chk("R8 data held while stalled", {out_err, out_data}, e);
    chk("R8 valid held while stalled", {128'd0, out_valid}, {128'd0, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 waiting request taken on release", {out_err, out_data}, e2);
    @(negedge clk);
    chk("R8 valid drops after consume", {128'd0, out_valid}, '0);

    // R9 mid-run reset with a held result
    out_ready = 1'b0;
    drive(VEC[12]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;
    chk("R9 reset clears held result", {out_valid, out_err, out_data}, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule